// File: doc/BRIEF.md
# Serial Gain Word Loader

This block is the digital control front end of a programmable-gain line driver. A host loads an 8-bit gain code over a three-wire serial port: a serial clock, a data line and a load-enable line that is held low while bits are being loaded. The code enters most significant bit first. Each bit passes through a master stage and then a slave shift stage. The held gain output changes only when the load-enable rises, so the analog path never sees a partly loaded word.

All serial and power-control pins are sampled by a fast system clock through two-flop synchronizers. Pin edges are found by comparing each synchronized sample with the previous one. The block also combines a transmit-on input and an active-low sleep input into a two-bit power-mode code. A flag marks latched codes above the maximum-gain code of 128. Those codes are passed through unchanged, and downstream logic decides how to handle them.

Top module: `gain_word_loader`

## Requirements
- R1: After reset, the gain output is 0 (minimum gain), the over-range flag is 0 and the power mode reads 01 (transmit off).
- R2: An 8-bit word shifted in with the most significant bit first appears unchanged on the gain output after it is committed.
- R3: A data bit is captured on the rising serial-clock edge. A change of the data line while the serial clock stays high does not alter the captured bit.
- R4: The captured bit enters the shift register only on the following falling serial-clock edge. A rise that has no matching fall before the commit leaves that bit out of the committed word.
- R5: A rising load-enable copies the shift register to the gain output 3 system clocks after the pin changes.
- R6: While load-enable is high, serial clocks change neither the master stage nor the shift register.
- R7: A falling load-enable leaves the gain output unchanged. The gain output holds its value at all times except at a commit.
- R8: The power mode is 00 whenever the sleep input is low, whatever the transmit input is. Otherwise it is 10 when transmit is on and 01 when transmit is off. The code 11 never occurs.
- R9: The over-range flag is 1 exactly when the held gain code is greater than 128. Code 128 itself gives 0.
- R10: Gain codes from 129 to 255 are held and output without change.
- R11: A falling serial-clock edge and a rising load-enable that reach the synchronized domain in the same cycle commit the register contents from before that shift. The pending bit is dropped.
- R12: The power mode follows a change on the sleep or transmit pins 3 system clocks after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4 times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock pin |
| ser_data | input | 1 | Serial data pin, MSB first |
| ser_load_n | input | 1 | Load enable: low while loading, rising edge commits |
| tx_on | input | 1 | Transmit enable request |
| sleep_n | input | 1 | Active-low sleep request |
| gain_code | output | 8 | Held gain code |
| gain_over | output | 1 | Held code is above 128 |
| pwr_mode | output | 2 | 00 sleep, 01 transmit off, 10 transmit on |

## Verification
The shift path and the commit path can act in the same system cycle. This happens when the serial clock falls in the same cycle that the load-enable rises. The bench drives both pins in one step, so both reach the synchronized domain in the same cycle. It then checks that the committed code lacks the pending bit. A second case leaves the last falling edge until after the commit and checks that the late fall is ignored. Both cases are also compared on every clock against a behavioural model built on a queue of pin samples.

// File: rtl/gwl_pkg.sv
package gwl_pkg;

  localparam logic [1:0] PM_SLEEP  = 2'b00;
  localparam logic [1:0] PM_TX_OFF = 2'b01;
  localparam logic [1:0] PM_TX_ON  = 2'b10;

  // Power mode with sleep taking priority over the transmit request.
  function automatic logic [1:0] f_mode(input logic asleep_n, input logic tx);
    if (!asleep_n)
      return PM_SLEEP;
    else if (tx)
      return PM_TX_ON;
    else
      return PM_TX_OFF;
  endfunction

  // Rising and falling detection from the current and previous samples.
  function automatic logic f_rise(input logic now_v, input logic was_v);
    return now_v & ~was_v;
  endfunction

  function automatic logic f_fall(input logic now_v, input logic was_v);
    return ~now_v & was_v;
  endfunction

endpackage

// File: rtl/gwl_sync.sv
module gwl_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] now_o,
  output logic [W-1:0] was_o
);

  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) was_o <= RST_VAL;
    else        was_o <= chain[STAGES-1];
  end

  assign now_o = chain[STAGES-1];

endmodule

// File: rtl/gwl_shifter.sv
module gwl_shifter #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              data_s,
  input  logic              load_s,
  output logic [CODE_W-1:0] shreg_o
);

  logic master_q;
  logic cap_en;
  logic shift_en;

  function automatic logic [CODE_W-1:0] f_push(input logic [CODE_W-1:0] cur,
                                               input logic b);
    return {cur[CODE_W-2:0], b};
  endfunction

  assign cap_en   = sclk_rise & ~load_s;
  assign shift_en = sclk_fall & ~load_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      master_q <= 1'b0;
    else if (cap_en) master_q <= data_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shreg_o <= '0;
    else if (shift_en) shreg_o <= f_push(shreg_o, master_q);
  end

  AST_LOCKED_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    load_s |=> $stable(shreg_o)); // R6

  AST_MASTER_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(master_q)); // R3

  AST_SHIFT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(shreg_o)); // R4

endmodule

// File: rtl/gwl_mode.sv
module gwl_mode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_s,
  input  logic       tx_s,
  output logic [1:0] mode_o
);
  import gwl_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_o <= PM_TX_OFF;
    else        mode_o <= f_mode(sleep_s, tx_s);
  end

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'b11); // R8

  AST_SLEEP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_s |=> mode_o == PM_SLEEP); // R8

endmodule

// File: rtl/gain_word_loader.sv
module gain_word_loader #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_CODE    = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load_n,
  input  logic              tx_on,
  input  logic              sleep_n,
  output logic [CODE_W-1:0] gain_code,
  output logic              gain_over,
  output logic [1:0]        pwr_mode
);
  import gwl_pkg::*;

  // Pin bundle order: {sleep_n, tx_on, load, data, sclk}
  localparam int          NPIN    = 5;
  localparam int          P_SCLK  = 0;
  localparam int          P_DATA  = 1;
  localparam int          P_LOAD  = 2;
  localparam int          P_TX    = 3;
  localparam int          P_SLEEP = 4;
  localparam logic [NPIN-1:0] PIN_RST = 5'b10100;

  logic [NPIN-1:0]   pins;
  logic [NPIN-1:0]   s_now;
  logic [NPIN-1:0]   s_was;
  logic              sclk_rise;
  logic              sclk_fall;
  logic              load_rise;
  logic              load_fall;
  logic [CODE_W-1:0] shreg;
  logic [CODE_W-1:0] gain_q;

  function automatic logic f_over(input logic [CODE_W-1:0] code);
    return int'(code) > MAX_CODE;
  endfunction

  assign pins = {sleep_n, tx_on, ser_load_n, ser_data, ser_clk};

  gwl_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pins),
    .now_o (s_now),
    .was_o (s_was)
  );

  assign sclk_rise = f_rise(s_now[P_SCLK], s_was[P_SCLK]);
  assign sclk_fall = f_fall(s_now[P_SCLK], s_was[P_SCLK]);
  assign load_rise = f_rise(s_now[P_LOAD], s_was[P_LOAD]);
  assign load_fall = f_fall(s_now[P_LOAD], s_was[P_LOAD]);

  gwl_shifter #(.CODE_W(CODE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .data_s    (s_now[P_DATA]),
    .load_s    (s_now[P_LOAD]),
    .shreg_o   (shreg)
  );

  gwl_mode u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep_s (s_now[P_SLEEP]),
    .tx_s    (s_now[P_TX]),
    .mode_o  (pwr_mode)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gain_q <= '0;
    else if (load_rise) gain_q <= shreg;
  end

  assign gain_code = gain_q;
  assign gain_over = f_over(gain_q);

  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise |=> gain_q == $past(shreg)); // R5

  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_rise |=> $stable(gain_q)); // R7

  AST_OPEN_KEEPS_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    load_fall |=> $stable(gain_code)); // R7

  AST_OVER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    gain_over |-> gain_code[CODE_W-1] && (gain_code[CODE_W-2:0] != '0)); // R9

endmodule

// File: tb/sim_gain_word_loader.sv
module sim_gain_word_loader;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic       ser_load_n = 1'b1;
  logic       tx_on = 1'b0;
  logic       sleep_n = 1'b1;
  logic [7:0] gain_code;
  logic       gain_over;
  logic [1:0] pwr_mode;

  int vectors = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  gain_word_loader u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load_n(ser_load_n), .tx_on(tx_on), .sleep_n(sleep_n),
    .gain_code(gain_code), .gain_over(gain_over), .pwr_mode(pwr_mode)
  );

  // Reference model: a queue of raw pin samples, index 0 newest.
  typedef struct packed { bit slp; bit tx; bit ld; bit dat; bit sck; } pins_t;
  pins_t hist[$];
  int m_gain, m_sr, m_master, m_mode;

  task automatic model_reset();
    pins_t r;
    r = '{slp:1, tx:0, ld:1, dat:0, sck:0};
    hist = {r, r, r};
    m_gain = 0; m_sr = 0; m_master = 0; m_mode = 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      pins_t cur, prv, smp;
      int nm, ns, ng;
      cur = hist[1]; prv = hist[2];
      nm = m_master; ns = m_sr; ng = m_gain;
      if (cur.sck && !prv.sck && !cur.ld) nm = cur.dat;
      if (!cur.sck && prv.sck && !cur.ld) ns = (m_sr * 2 + m_master) % 256;
      if (cur.ld && !prv.ld) ng = m_sr;
      m_mode = !cur.slp ? 0 : (cur.tx ? 2 : 1);
      m_master = nm; m_sr = ns; m_gain = ng;
      smp = '{slp:sleep_n, tx:tx_on, ld:ser_load_n, dat:ser_data, sck:ser_clk};
      hist.push_front(smp);
      if (hist.size() > 4) void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (gain_code !== m_gain[7:0]) begin
        bad++;
        $display("FAIL R5 model gain: actual %0d expected %0d", gain_code, m_gain);
      end
      if (gain_over !== (m_gain > 128)) begin
        bad++;
        $display("FAIL R9 model flag: actual %0d expected %0d", gain_over, m_gain > 128);
      end
      if (pwr_mode !== m_mode[1:0]) begin
        bad++;
        $display("FAIL R12 model mode: actual %0d expected %0d", pwr_mode, m_mode);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic send_bit(input bit b, input bit wiggle);
    ser_data = b; tick(2);
    ser_clk = 1'b1; tick(1);
    if (wiggle) ser_data = ~b;
    tick(1);
    ser_clk = 1'b0; tick(2);
  endtask

  task automatic send_word(input logic [7:0] w, input bit wiggle);
    for (int i = 7; i >= 0; i--) send_bit(w[i], wiggle);
  endtask

  task automatic load_word(input logic [7:0] w, input bit wiggle);
    ser_load_n = 1'b0; tick(4);
    send_word(w, wiggle);
    ser_load_n = 1'b1; tick(4);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] expw;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 gain", gain_code, 0);
    chk("R1 flag", gain_over, 0);
    chk("R1 mode", pwr_mode, 1);

    // R12 latency and R8 encoding
    tx_on = 1'b1; tick(2);
    chk("R12 mode before 3 clocks", pwr_mode, 1);
    tick(1);
    chk("R12 mode after 3 clocks", pwr_mode, 2);
    sleep_n = 1'b0; tick(3);
    chk("R8 sleep over tx on", pwr_mode, 0);
    tx_on = 1'b0; tick(3);
    chk("R8 sleep with tx off", pwr_mode, 0);
    sleep_n = 1'b1; tick(3);
    chk("R8 tx off", pwr_mode, 1);

    // R2 / R5 basic word with commit latency
    ser_load_n = 1'b0; tick(4);
    send_word(8'hA5, 0);
    chk("R7 hold during load", gain_code, 0);
    ser_load_n = 1'b1; tick(2);
    chk("R5 before commit", gain_code, 0);
    tick(1);
    chk("R2 word A5", gain_code, 8'hA5);

    // R9 boundary and R10 pass-through
    load_word(8'h80, 0);
    chk("R9 code 128 value", gain_code, 128);
    chk("R9 code 128 flag", gain_over, 0);
    load_word(8'hC3, 0);
    chk("R10 code C3", gain_code, 8'hC3);
    chk("R9 flag C3", gain_over, 1);

    // R6 clocks while load high are ignored
    send_word(8'h0F, 0);
    ser_load_n = 1'b0; tick(4);
    chk("R7 open keeps gain", gain_code, 8'hC3);
    ser_load_n = 1'b1; tick(4);
    chk("R6 locked clocks ignored", gain_code, 8'hC3);

    // R3 data changing while clock high
    load_word(8'h5A, 1);
    chk("R3 capture on rise", gain_code, 8'h5A);

    // R4 last fall arrives after commit
    ser_load_n = 1'b0; tick(4);
    for (int i = 7; i >= 1; i--) send_bit(expw_bit(8'h3C, i), 0);
    ser_data = 1'b0; tick(2);
    ser_clk = 1'b1; tick(2);
    ser_load_n = 1'b1; tick(4);
    ser_clk = 1'b0; tick(4);
    expw = 8'((32'h5A << 7) | (32'h3C >> 1));
    chk("R4 missing fall drops bit", gain_code, expw);
    ser_load_n = 1'b0; tick(4);
    ser_load_n = 1'b1; tick(4);
    chk("R6 late fall not shifted", gain_code, expw);

    // R11 fall and commit in the same cycle
    ser_load_n = 1'b0; tick(4);
    for (int i = 7; i >= 1; i--) send_bit(expw_bit(8'h96, i), 0);
    ser_data = 1'b0; tick(2);
    ser_clk = 1'b1; tick(2);
    ser_clk = 1'b0; ser_load_n = 1'b1; tick(4);
    expw = 8'((32'(expw) << 7) | (32'h96 >> 1));
    chk("R11 collision drops pending bit", gain_code, expw);

    tick(4);
    finish_run();
  end

  function automatic bit expw_bit(input logic [7:0] w, input int i);
    return w[i];
  endfunction

endmodule